// File: doc/BRIEF.md
# Asynchronous Static RAM Interface Controller

This block lets a synchronous host issue single-byte reads and writes to an asynchronous 128K x 8 static RAM. The host side is a simple request port with ready and read-data-valid signals. The memory side drives the address bus and a bidirectional byte bus. It also drives four control lines: an active-low select, an active-high enable, an active-low output enable and an active-low write strobe.

Every phase of an access is timed by a run-time count in clock cycles. The counted phases are address setup, write pulse, data setup, hold, recovery, read access and bus turnaround. A count of zero behaves as one cycle.

A two-bit mode input picks which control line frames a write: the write strobe, the select or the enable. All three framings use the same counts. In the select and enable framings the memory is deselected outside the pulse. Each access starts from idle with every control line inactive, so consecutive writes always see a deasserted control between pulses.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, select is high, enable is low, output enable is high, write strobe is high, ready is high and read-data-valid is low.
- R2: Ready is high only while idle. A request is taken on a rising edge where request and ready are both high. Request is ignored while ready is low.
- R3: A read holds select low, enable high, output enable low and write strobe high for the access count. The byte on the bus at the end of that window is returned.
- R4: Read-data-valid is high for exactly one cycle. It is first seen in the cycle after the edge that is access-count edges past the accepting edge.
- R5: Mode value 0 frames the write with the write strobe, 1 with the select, and 2 with the enable. Value 3 behaves as 0. The selected line is the one that makes the write combination (strobe low, select low, enable high) begin and end.
- R6: The write combination lasts exactly max(pulse, data-setup) cycles.
- R7: The address is stable for at least the setup count before the write combination begins. It stays constant through the pulse and the hold.
- R8: Write data is stable on the bus for at least max(pulse, data-setup) cycles, up to and including the last cycle of the write combination.
- R9: For two writes issued back to back, the write combination is inactive for exactly hold + recovery + 1 + setup cycles between them.
- R10: A write keeps ready low for setup + max(pulse, data-setup) + hold + recovery cycles. A read keeps ready low for access + turnaround cycles. Any count of 0 acts as 1.
- R11: Output enable is high whenever the controller drives the data bus. Write strobe and output enable are never low together.
- R12: After the read byte is captured, the memory stays deselected with the bus released for the turnaround count before ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Byte address |
| wdata_i | input | 8 | Write byte |
| ready_o | output | 1 | Controller idle, request can be taken |
| rvalid_o | output | 1 | Read byte valid, one-cycle pulse |
| rdata_o | output | 8 | Read byte |
| cfg_mode_i | input | 2 | Write framing: 0 strobe, 1 select, 2 enable, 3 strobe |
| cfg_setup_i | input | 4 | Address setup cycles |
| cfg_pulse_i | input | 4 | Write pulse cycles |
| cfg_dsetup_i | input | 4 | Data setup cycles before end of pulse |
| cfg_hold_i | input | 4 | Address and data hold cycles |
| cfg_recov_i | input | 4 | Write recovery cycles |
| cfg_access_i | input | 4 | Read access cycles |
| cfg_turn_i | input | 4 | Bus turnaround cycles after a read |
| mem_addr_o | output | 17 | Memory address bus |
| mem_dq_io | inout | 8 | Memory data bus |
| mem_cs_n_o | output | 1 | Memory select, active low |
| mem_ce_o | output | 1 | Memory enable, active high |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_we_n_o | output | 1 | Memory write strobe, active low |

## Verification
The hardest cases to reach are those where a read-data capture one cycle early, or a pulse one cycle short, would still produce correct-looking data. The bench's memory responder therefore drives the inverted byte until the programmed access count has elapsed on a stable address. It also measures write-combination length, address and data stability, and the inactive gap directly on the control pins. The sweep covers every framing mode, including the alias value, with counts that include zero and cases where data setup exceeds the pulse. Two writes are issued back to back in each configuration, so the recovery gap is measured with a single idle cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RACC  = 3'd1,
      ST_RTURN = 3'd2,
      ST_WSET  = 3'd3,
      ST_WPUL  = 3'd4,
      ST_WHLD  = 3'd5,
      ST_WREC  = 3'd6
   } phase_e;

   localparam logic [1:0] FRAME_WE = 2'd0;
   localparam logic [1:0] FRAME_CS = 2'd1;
   localparam logic [1:0] FRAME_CE = 2'd2;

   typedef struct packed {
      logic cs_n;
      logic ce;
      logic oe_n;
      logic we_n;
   } mem_ctl_t;

   localparam mem_ctl_t CTL_OFF = '{cs_n: 1'b1, ce: 1'b0, oe_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             last_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= (len_i == '0) ? '0 : len_i - 1'b1;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last_o = (cnt_q == '0);

   // R10
   timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && len_i > 1) |=> !last_o);

endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
   import sram_ctrl_pkg::*;
(
   input  phase_e     phase_i,
   input  logic [1:0] frame_i,
   output mem_ctl_t   ctl_o
);

   mem_ctl_t framed;

   // Levels outside the pulse: the framing line sits inactive, the other two active.
   always_comb begin
      unique case (frame_i)
         FRAME_CS: framed = '{cs_n: 1'b1, ce: 1'b1, oe_n: 1'b1, we_n: 1'b0};
         FRAME_CE: framed = '{cs_n: 1'b0, ce: 1'b0, oe_n: 1'b1, we_n: 1'b0};
         default:  framed = '{cs_n: 1'b0, ce: 1'b1, oe_n: 1'b1, we_n: 1'b1};
      endcase
   end

   always_comb begin
      unique case (phase_i)
         ST_RACC:                   ctl_o = '{cs_n: 1'b0, ce: 1'b1, oe_n: 1'b0, we_n: 1'b1};
         ST_WPUL:                   ctl_o = '{cs_n: 1'b0, ce: 1'b1, oe_n: 1'b1, we_n: 1'b0};
         ST_WSET, ST_WHLD, ST_WREC: ctl_o = framed;
         default:                   ctl_o = CTL_OFF;
      endcase
   end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              ready_o,
   output logic              rvalid_o,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [1:0]        cfg_mode_i,
   input  logic [CNT_W-1:0]  cfg_setup_i,
   input  logic [CNT_W-1:0]  cfg_pulse_i,
   input  logic [CNT_W-1:0]  cfg_dsetup_i,
   input  logic [CNT_W-1:0]  cfg_hold_i,
   input  logic [CNT_W-1:0]  cfg_recov_i,
   input  logic [CNT_W-1:0]  cfg_access_i,
   input  logic [CNT_W-1:0]  cfg_turn_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   inout  wire  [DATA_W-1:0] mem_dq_io,
   output logic              mem_cs_n_o,
   output logic              mem_ce_o,
   output logic              mem_oe_n_o,
   output logic              mem_we_n_o
);

   localparam logic [DATA_W-1:0] BUS_RELEASED = {DATA_W{1'bz}};

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_async_ctrl: widths must be positive");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("sram_async_ctrl: CNT_W must be 1..16");
      end
   endgenerate

   phase_e            state_q, state_d;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q, rdata_q;
   logic [1:0]        frame_q;
   logic              rvalid_q;
   logic              tmr_last, tmr_load;
   logic [CNT_W-1:0]  tmr_len, pulse_eff;
   logic              dq_en;
   mem_ctl_t          ctl;

   // The write window must cover both the pulse and the data setup demand.
   assign pulse_eff = (cfg_pulse_i >= cfg_dsetup_i) ? cfg_pulse_i : cfg_dsetup_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (req_i) state_d = we_i ? ST_WSET : ST_RACC;
         ST_RACC:  if (tmr_last) state_d = ST_RTURN;
         ST_RTURN: if (tmr_last) state_d = ST_IDLE;
         ST_WSET:  if (tmr_last) state_d = ST_WPUL;
         ST_WPUL:  if (tmr_last) state_d = ST_WHLD;
         ST_WHLD:  if (tmr_last) state_d = ST_WREC;
         ST_WREC:  if (tmr_last) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (state_d)
         ST_RACC:  tmr_len = cfg_access_i;
         ST_RTURN: tmr_len = cfg_turn_i;
         ST_WSET:  tmr_len = cfg_setup_i;
         ST_WPUL:  tmr_len = pulse_eff;
         ST_WHLD:  tmr_len = cfg_hold_i;
         ST_WREC:  tmr_len = cfg_recov_i;
         default:  tmr_len = '0;
      endcase
   end

   assign tmr_load = (state_d != state_q);

   sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .len_i  (tmr_len),
      .last_o (tmr_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         addr_q   <= '0;
         wdata_q  <= '0;
         frame_q  <= FRAME_WE;
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         rvalid_q <= (state_q == ST_RACC) && tmr_last;
         if (state_q == ST_IDLE && req_i) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            frame_q <= cfg_mode_i;
         end
         if (state_q == ST_RACC && tmr_last) begin
            rdata_q <= mem_dq_io;
         end
      end
   end

   sram_strobe_gen i_strobe (
      .phase_i (state_q),
      .frame_i (frame_q),
      .ctl_o   (ctl)
   );

   assign dq_en      = (state_q == ST_WSET) || (state_q == ST_WPUL) || (state_q == ST_WHLD);
   assign mem_dq_io  = dq_en ? wdata_q : BUS_RELEASED;
   assign mem_addr_o = addr_q;
   assign mem_cs_n_o = ctl.cs_n;
   assign mem_ce_o   = ctl.ce;
   assign mem_oe_n_o = ctl.oe_n;
   assign mem_we_n_o = ctl.we_n;
   assign ready_o    = (state_q == ST_IDLE);
   assign rvalid_o   = rvalid_q;
   assign rdata_o    = rdata_q;

   // R2
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (mem_cs_n_o && !mem_ce_o && mem_oe_n_o && mem_we_n_o));

   // R4
   rvalid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid_o |=> !rvalid_o);

   // R11
   bus_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_en |-> (mem_oe_n_o && !(mem_we_n_o == 1'b0 && mem_oe_n_o == 1'b0)));

   // R7
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WHLD || state_q == ST_WPUL) |-> $stable(mem_addr_o));

   // R6
   write_combo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n_o && !mem_cs_n_o && mem_ce_o) |-> (state_q == ST_WPUL && dq_en));

   // R3
   read_combo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid_o |-> $past(!mem_cs_n_o && mem_ce_o && !mem_oe_n_o && mem_we_n_o));

endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, we = 1'b0;
   logic [16:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        ready, rvalid;
   logic [7:0]  rdata;
   logic [1:0]  mode = '0;
   logic [3:0]  c_s = 4'd1, c_p = 4'd1, c_d = 4'd1, c_h = 4'd1, c_r = 4'd1, c_a = 4'd1, c_t = 4'd1;
   logic [16:0] m_addr;
   wire  [7:0]  dq_w;
   logic        m_cs_n, m_ce, m_oe_n, m_we_n;

   int checks = 0, errs = 0;

   always #5 clk = ~clk;

   sram_async_ctrl i_sram_async_ctrl (
      .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
      .ready_o(ready), .rvalid_o(rvalid), .rdata_o(rdata), .cfg_mode_i(mode),
      .cfg_setup_i(c_s), .cfg_pulse_i(c_p), .cfg_dsetup_i(c_d), .cfg_hold_i(c_h),
      .cfg_recov_i(c_r), .cfg_access_i(c_a), .cfg_turn_i(c_t),
      .mem_addr_o(m_addr), .mem_dq_io(dq_w), .mem_cs_n_o(m_cs_n), .mem_ce_o(m_ce),
      .mem_oe_n_o(m_oe_n), .mem_we_n_o(m_we_n)
   );

   // Behavioural memory responder with measurement of the write window.
   logic [7:0]  mem [256];
   logic        rd_act, wr_act;
   logic [7:0]  rsp_val;
   int          rd_cnt = 0;
   logic        prev_wr = 1'b0, prev_cs_n = 1'b1, prev_ce = 1'b0, prev_we_n = 1'b1;
   logic [16:0] prev_addr = '0, wr_addr = '0;
   logic [7:0]  prev_dq = '0, wr_data = '0;
   int astab = 0, dstab = 0, gap = 0, pulse_cnt = 0, addr_err = 0, oe_viol = 0;
   int last_pulse = 0, last_term = -1, last_gap = 0, last_astab = 0, last_dstab = 0;

   assign rd_act = !m_cs_n && m_ce && !m_oe_n && m_we_n;
   assign wr_act = !m_cs_n && m_ce && !m_we_n;
   always_comb rsp_val = (rd_cnt >= int'(cl(c_a)) - 1) ? mem[m_addr[7:0]] : ~mem[m_addr[7:0]];
   assign dq_w = rd_act ? rsp_val : 8'hzz;

   function automatic int cl(input logic [3:0] v);
      return (v == 4'd0) ? 1 : int'(v);
   endfunction

   always @(posedge clk) begin
      astab = (m_addr == prev_addr) ? astab + 1 : 0;
      dstab = (dq_w == prev_dq) ? dstab + 1 : 0;
      if (!m_oe_n && !m_we_n) oe_viol++;
      if (wr_act) begin
         if (!prev_wr) begin
            last_astab = astab;
            last_gap   = gap;
            pulse_cnt  = 0;
            wr_addr    = m_addr;
         end else if (m_addr != wr_addr) begin
            addr_err++;
         end
         pulse_cnt++;
         wr_data    = dq_w;
         last_dstab = dstab + 1;
         gap        = 0;
      end else begin
         if (prev_wr) begin
            mem[wr_addr[7:0]] = wr_data;
            last_pulse = pulse_cnt;
            if (!prev_we_n && m_we_n)     last_term = 0;
            else if (prev_cs_n == 1'b0 && m_cs_n) last_term = 1;
            else if (prev_ce && !m_ce)    last_term = 2;
            else                          last_term = 9;
         end
         gap++;
      end
      if (rd_act && m_addr == prev_addr) rd_cnt = rd_cnt + 1;
      else rd_cnt = rd_act ? 1 : 0;
      prev_wr = wr_act; prev_cs_n = m_cs_n; prev_ce = m_ce; prev_we_n = m_we_n;
      prev_addr = m_addr; prev_dq = dq_w;
   end

   task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req_tag, act, exp);
      end
   endtask

   // Called at a falling edge with the controller idle; returns at a falling edge with ready high.
   task automatic do_op(input bit w, input logic [16:0] a, input logic [7:0] d,
                        output int lat_ready, output int lat_rv, output logic [7:0] rd);
      int n;
      chk(ready == 1'b1, "R2 ready before request", int'(ready), 1);
      req = 1'b1; we = w; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      req = 1'b0; addr = ~a; wdata = ~d;
      n = 0; lat_rv = -1; rd = '0;
      while (!ready && n < 200) begin
         if (rvalid) begin
            if (lat_rv >= 0) chk(1'b0, "R4 second valid pulse", n, lat_rv);
            lat_rv = n; rd = rdata;
         end
         @(negedge clk);
         n++;
      end
      lat_ready = n;
   endtask

   initial begin
      #2_000_000;
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      int lr, lv, pe;
      logic [7:0] rd;
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
      repeat (3) @(negedge clk);
      // R1 reset levels
      chk(m_cs_n == 1'b1 && m_ce == 1'b0 && m_oe_n == 1'b1 && m_we_n == 1'b1, "R1 controls in reset",
          int'({m_cs_n, m_ce, m_oe_n, m_we_n}), 4'b1011);
      chk(ready == 1'b1 && rvalid == 1'b0, "R1 host flags in reset", int'({ready, rvalid}), 2'b10);
      rst_n = 1'b1;
      @(negedge clk);
      chk(m_cs_n && !m_ce && m_oe_n && m_we_n && ready && !rvalid, "R1 idle after reset",
          int'({m_cs_n, m_ce, m_oe_n, m_we_n, ready, rvalid}), 6'b101110);
      for (int m = 0; m < 4; m++) begin
         for (int k = 0; k < 4; k++) begin
            logic [16:0] wa;
            logic [7:0]  d0, d1;
            int base, em;
            mode = 2'(m);
            c_s = 4'(1 + k % 2); c_p = 4'(k); c_d = (k == 1) ? 4'd3 : 4'd1;
            c_h = 4'(1 + k / 2); c_r = 4'(k % 3); c_a = 4'(1 + k); c_t = (k % 2 == 1) ? 4'd2 : 4'd0;
            pe   = (cl(c_p) > cl(c_d)) ? cl(c_p) : cl(c_d);
            em   = (m == 3) ? 0 : m;
            base = m * 32 + k * 4 + 1;
            wa   = 17'(base) | (17'(k + 1) << 12);
            d0   = 8'(8'h5A ^ base);
            d1   = 8'(8'hA3 + base);
            // first write
            do_op(1'b1, wa, d0, lr, lv, rd);
            chk(lr == cl(c_s) + pe + cl(c_h) + cl(c_r), "R10 write busy", lr, cl(c_s) + pe + cl(c_h) + cl(c_r));
            chk(last_pulse == pe, "R6 write window", last_pulse, pe);
            chk(last_term == em, "R5 terminating line", last_term, em);
            chk(last_astab >= cl(c_s), "R7 address setup", last_astab, cl(c_s));
            chk(last_dstab >= pe, "R8 data stable before end", last_dstab, pe);
            // second write issued back to back
            do_op(1'b1, wa + 17'd1, d1, lr, lv, rd);
            chk(last_gap == cl(c_h) + cl(c_r) + 1 + cl(c_s), "R9 inactive gap", last_gap,
                cl(c_h) + cl(c_r) + 1 + cl(c_s));
            chk(last_term == em, "R5 terminating line 2", last_term, em);
            chk(addr_err == 0, "R7 address constant in pulse", addr_err, 0);
            // reads
            do_op(1'b0, wa, 8'h00, lr, lv, rd);
            chk(rd == d0, "R3 read byte", int'(rd), int'(d0));
            chk(lv == cl(c_a), "R4 valid latency", lv, cl(c_a));
            chk(lr - lv == cl(c_t), "R12 turnaround", lr - lv, cl(c_t));
            chk(lr == cl(c_a) + cl(c_t), "R10 read busy", lr, cl(c_a) + cl(c_t));
            do_op(1'b0, wa + 17'd1, 8'h00, lr, lv, rd);
            chk(rd == d1, "R3 read byte 2", int'(rd), int'(d1));
            chk(ready && m_cs_n && !m_ce && !rvalid, "R2 idle after read",
                int'({ready, m_cs_n, m_ce, rvalid}), 4'b1100);
         end
      end
      chk(oe_viol == 0, "R11 strobe with output enable", oe_viol, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule